// File: doc/BRIEF.md
# Long-Press Reset Pulse Timer

This block turns a long press of a push-button into a fixed-width system reset pulse. The button input is active low. While it stays low, a counter measures the hold time. A press that stays low for the full hold delay makes the block pull the reset line low for a fixed recovery width. A press that ends earlier has no effect. The nominal delay is 7.5 s, and the allowed window is 6.0 s to 9.0 s. The nominal pulse is 400 ms, within 320 ms to 480 ms. Both are set as parameters in clock cycles. The default values assume a 32.768 kHz clock.

The output is a pull-low enable. When the enable is high, an open-drain pad drives the line low. When it is low, the pad releases the line. Once a pulse has started, it always runs its full width. After a pulse, the block waits for the button to be released before it can fire again.

A delay-select input chooses the zero-delay test mode. In test mode the pulse starts as soon as the synchronized button is seen low. The select level is taken only while the button is released, so it is in effect after power-up. Both the button and the select input pass through a two-flop synchronizer before any logic uses them.

Top module: `lp_reset_timer`

## Requirements
- R1: While `rst_ni` is low and after it is released, `rst_pull_o` is 0, which means the line is released. Until the first long press, the output stays 0.
- R2: In normal mode, when `btn_ni` goes low and stays low, `rst_pull_o` rises on the (HOLD_CYC+2)-th rising clock edge after the change. Two of those edges are synchronizer latency.
- R3: A press that stays low for HOLD_CYC-1 cycles or fewer produces no pulse. Any high sample clears the hold count, so two such presses separated by a release do not add up.
- R4: Every pulse keeps `rst_pull_o` at 1 for exactly PULSE_CYC cycles, whatever `btn_ni` does during the pulse. This includes a release before the pulse starts and a button held through the pulse.
- R5: If the button is still low when a pulse ends, no further pulse starts until the button has been seen high. A later press then behaves as in R2.
- R6: In test mode (select latched at 1), `rst_pull_o` rises on the 3rd rising edge after `btn_ni` falls. The pulse lasts PULSE_CYC cycles, and the rule in R5 still applies.
- R7: The `test_sel_i` level is taken into the mode register only while the synchronized button is high. This includes the time during and just after reset. Changes while the button is low are ignored for the current press.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-up) |
| btn_ni | input | 1 | Push-button reset request, active low, asynchronous |
| test_sel_i | input | 1 | Delay select: 1 selects zero-delay test mode, asynchronous |
| rst_pull_o | output | 1 | Pull-low enable for the open-drain reset line (1 = drive low) |

## Verification
The assertions check four rules on every cycle:
- no pulse is longer than PULSE_CYC, and none ends early;
- in normal mode, no pulse starts unless at least HOLD_CYC consecutive low samples came before it;
- a second pulse needs a release in between;
- the mode register never moves while the synchronized button is low.

Only the bench scenarios can show the exact rise latency, the HOLD_CYC-1 versus HOLD_CYC boundary, and the clearing of the count between short presses. The same holds for the test mode taking effect after a select change made mid-press, and for power-up with the select high.

// File: rtl/lp_reset_timer_pkg.sv
package lp_reset_timer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_PULSE = 2'd2,
    ST_WAIT  = 2'd3
  } lp_state_e;
endpackage

// File: rtl/lp_sync.sv
module lp_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/lp_mode_latch.sv
module lp_mode_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_low_i,
  input  logic sel_i,
  output logic test_mode_o
);
  // select is tracked only while the button is released
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         test_mode_o <= 1'b0;
    else if (!btn_low_i) test_mode_o <= sel_i;
  end
endmodule

// File: rtl/lp_hold_fsm.sv
module lp_hold_fsm
  import lp_reset_timer_pkg::*;
#(
  parameter int unsigned HOLD_CYC  = 245760,
  parameter int unsigned PULSE_CYC = 13107
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_low_i,
  input  logic test_mode_i,
  output logic pull_o
);
  localparam int unsigned MAX_CYC = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int unsigned CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LAST = CNT_W'(PULSE_CYC - 1);

  lp_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (btn_low_i) begin
          if (test_mode_i) state_d = ST_PULSE;
          else begin
            state_d = ST_HOLD;
            cnt_d   = CNT_W'(1);
          end
        end
      end
      ST_HOLD: begin
        if (!btn_low_i) begin
          state_d = ST_IDLE;
          cnt_d   = '0;
        end else if (test_mode_i || cnt_q == HOLD_LAST) begin
          state_d = ST_PULSE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_PULSE: begin
        if (cnt_q == PULSE_LAST) begin
          state_d = btn_low_i ? ST_WAIT : ST_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_WAIT: begin
        cnt_d = '0;
        if (!btn_low_i) state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pull_o = (state_q == ST_PULSE);
endmodule

// File: rtl/lp_reset_timer.sv
module lp_reset_timer #(
  parameter int unsigned HOLD_CYC    = 245760,
  parameter int unsigned PULSE_CYC   = 13107,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic test_sel_i,
  output logic rst_pull_o
);
  logic btn_s;
  logic btn_low;
  logic sel_s;
  logic test_mode;

  lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_btn_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (btn_ni),
    .q_o   (btn_s)
  );

  lp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (test_sel_i),
    .q_o   (sel_s)
  );

  assign btn_low = ~btn_s;

  lp_mode_latch u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .btn_low_i  (btn_low),
    .sel_i      (sel_s),
    .test_mode_o(test_mode)
  );

  lp_hold_fsm #(.HOLD_CYC(HOLD_CYC), .PULSE_CYC(PULSE_CYC)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .btn_low_i  (btn_low),
    .test_mode_i(test_mode),
    .pull_o     (rst_pull_o)
  );
endmodule

// File: rtl/lp_reset_timer_chk.sv
module lp_reset_timer_chk #(
  parameter int unsigned HOLD_CYC  = 245760,
  parameter int unsigned PULSE_CYC = 13107
) (
  input logic clk_i,
  input logic rst_ni,
  input logic btn_low_i,
  input logic test_mode_i,
  input logic pull_i
);
  logic [31:0] low_run_q;
  logic [31:0] pulse_run_q;
  logic        armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run_q   <= '0;
      pulse_run_q <= '0;
      armed_q     <= 1'b1;
    end else begin
      if (!btn_low_i)              low_run_q <= '0;
      else if (low_run_q < HOLD_CYC) low_run_q <= low_run_q + 32'd1;
      pulse_run_q <= pull_i ? pulse_run_q + 32'd1 : 32'd0;
      if (pull_i)          armed_q <= 1'b0;
      else if (!btn_low_i) armed_q <= 1'b1;
    end
  end

  AST_PULSE_NOT_LONG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_i |-> pulse_run_q < PULSE_CYC); // R4
  AST_PULSE_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pull_i) |-> pulse_run_q == PULSE_CYC); // R4
  AST_HOLD_MET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(pull_i) && !test_mode_i) |-> low_run_q >= HOLD_CYC); // R2
  AST_NO_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_i) |-> armed_q); // R5
  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    btn_low_i |=> $stable(test_mode_i)); // R7
endmodule

bind lp_reset_timer lp_reset_timer_chk #(
  .HOLD_CYC (HOLD_CYC),
  .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .btn_low_i  (btn_low),
  .test_mode_i(test_mode),
  .pull_i     (rst_pull_o)
);

// File: tb/lp_reset_timer_tb.sv
`timescale 1ns/1ps
module lp_reset_timer_tb;
  localparam int HOLD  = 30;
  localparam int PULSE = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic sel = 1'b0;
  logic pull;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  lp_reset_timer #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE), .SYNC_STAGES(2)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .btn_ni    (btn_n),
    .test_sel_i(sel),
    .rst_pull_o(pull)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  // press, return edges until pull seen high (-1 if never)
  task automatic press_lat(input int limit, input int sel_at, output int lat);
    lat = -1;
    btn_n = 1'b0;
    for (int i = 1; i <= limit; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == sel_at) sel = 1'b1;
      if (pull) begin lat = i; break; end
    end
  endtask

  task automatic width(output int w);
    w = 0;
    while (pull && w < 4 * PULSE) begin w++; @(negedge clk); end
  endtask

  task automatic quiet(input int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
      if (pull) hits++;
    end
  endtask

  task automatic do_reset(input logic s);
    sel = s; btn_n = 1'b1; rst_n = 1'b0;
    cyc(3);
    chk("R1 pull in reset", int'(pull), 0);
    rst_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    int h;
    do_reset(1'b0);
    quiet(2 * HOLD, h);
    chk("R1 idle after reset", h, 0);
  endtask

  task automatic t_short();
    int h;
    btn_n = 1'b0; cyc(HOLD - 1); btn_n = 1'b1;
    quiet(2 * HOLD, h);
    chk("R3 single short press", h, 0);
    btn_n = 1'b0; cyc(HOLD - 1); btn_n = 1'b1; cyc(2);
    btn_n = 1'b0; cyc(HOLD - 1); btn_n = 1'b1;
    quiet(2 * HOLD, h);
    chk("R3 two short presses", h, 0);
  endtask

  task automatic t_long_held();
    int lat, w, h;
    press_lat(HOLD + 20, 0, lat);
    chk("R2 latency", lat, HOLD + 2);
    width(w);
    chk("R4 width held", w, PULSE);
    quiet(3 * HOLD, h);
    chk("R5 no second pulse while held", h, 0);
    btn_n = 1'b1; cyc(5);
    press_lat(HOLD + 20, 0, lat);
    chk("R5 rearm after release", lat, HOLD + 2);
    width(w);
    btn_n = 1'b1; cyc(5);
  endtask

  task automatic t_exact();
    int lat, w;
    btn_n = 1'b0; cyc(HOLD); btn_n = 1'b1;
    lat = -1;
    for (int i = 1; i <= 10; i++) begin
      if (pull) begin lat = i; break; end
      @(posedge clk); @(negedge clk);
    end
    chk("R2 exact hold fires", int'(lat > 0), 1);
    width(w);
    chk("R4 width after early release", w, PULSE);
    cyc(5);
  endtask

  task automatic t_sel_ignore();
    int lat, w;
    press_lat(HOLD + 20, 2, lat);
    chk("R7 select ignored mid-press", lat, HOLD + 2);
    width(w);
    btn_n = 1'b1; cyc(6);
    press_lat(20, 0, lat);
    chk("R7 select taken after release", lat, 3);
    width(w);
    btn_n = 1'b1; cyc(5);
  endtask

  task automatic t_test_mode();
    int lat, w, h;
    press_lat(20, 0, lat);
    chk("R6 test latency", lat, 3);
    width(w);
    chk("R6 test width", w, PULSE);
    quiet(3 * PULSE, h);
    chk("R6 test no second pulse while held", h, 0);
    btn_n = 1'b1; cyc(5);
  endtask

  task automatic t_powerup_test();
    int lat, w;
    do_reset(1'b1);
    press_lat(20, 0, lat);
    chk("R7 select latched at power-up", lat, 3);
    width(w);
    chk("R4 width power-up test", w, PULSE);
    btn_n = 1'b1; cyc(5);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_short();
    t_long_held();
    t_exact();
    t_sel_ignore();
    t_test_mode();
    t_powerup_test();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule